// File: doc/BRIEF.md
# Wakeup and Select Issue Scheduler

This block is the issue window of a small out-of-order core. Each micro-op arrives with up to two source tags, one destination tag and a class code. The class code chooses one of two fully pipelined execution units or a single divider that is not pipelined and has variable latency. Tags are carried in decoded (one-hot) form. Every cycle, every waiting entry compares its pending sources against all tags being broadcast and clears the ones it sees. No ordering or priority applies to this match. An entry with no pending sources is ready.

Each unit has its own picker, and the picker grants the ready entry of its class with the lowest slot index. Age plays no part in the choice. A granted entry leaves the window in the cycle it issues. The destination tag of a pipelined grant is fed straight back into the wakeup match, so a consumer can issue in the cycle right after its producer. The pipelined units never need a busy check.

The divider shares its writeback port with pipelined unit 1. A fixed number of cycles before its result is due, the divider raises a claim. The scheduler then withholds unit-1 issue in the one cycle whose result would land on the claimed slot. When the divide writes back, its destination tag is broadcast to waiting entries.

Top module: `issue_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge the window empties and any divider reservation is dropped. After that edge `disp_ready` is 1 and `iss_vld`, `wb_div` and `wb_pipe` are 0.
- R2: Source and destination tags are one-hot vectors of TAGW bits, and a source of all zeros means no dependency. An entry may not issue until every source tag it holds has been seen on the wakeup bus. The wakeup bus is the OR of `ext_bcast`, the destination tags of this cycle's unit-0 and unit-1 grants, and the divide tag being written back.
- R3: The class code in `disp_unit` is 0 for pipelined unit 0, 1 for pipelined unit 1 and 2 for the divider. Each unit's `iss_vld` bit goes high when at least one ready entry of its class exists, and it grants the one in the lowest slot. `iss_slot` and `iss_tag` then give that slot and its destination tag. Unit u occupies bit u of `iss_vld` and the u-th field of `iss_slot` and `iss_tag`.
- R4: A pipelined grant in cycle t makes its dependents eligible to issue in cycle t+1.
- R5: A tag broadcast in the same cycle that a consumer of it is dispatched counts as already seen by that consumer.
- R6: A divide is granted only while the divider is idle. The divider becomes busy in the cycle after a divide grant and stays busy through the cycle in which `wb_div` is high.
- R7: A `div_claim` pulse in cycle c makes `wb_div` high in cycle c+3. In that cycle the destination tag of the divide is placed on the wakeup bus.
- R8: A unit-1 grant in cycle t makes `wb_pipe` high in cycle t+1. No unit-1 grant is made in cycle c+2 after a claim in cycle c, so `wb_div` and `wb_pipe` are never high together.
- R9: `disp_ready` is low only when all entries are valid. An accepted dispatch fills the lowest free slot. A granted entry is freed in the cycle it issues and becomes free for dispatch in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Window has a free slot |
| disp_src0 | input | TAGW | First source tag, one-hot or zero |
| disp_src1 | input | TAGW | Second source tag, one-hot or zero |
| disp_dst | input | TAGW | Destination tag, one-hot |
| disp_unit | input | 2 | Class code: 0, 1 pipelined, 2 divider |
| ext_bcast | input | TAGW | Tags completed outside the window |
| div_claim | input | 1 | Divider result lands three cycles later |
| iss_vld | output | 3 | Grant per unit |
| iss_slot | output | 3*log2(N) | Granted slot per unit |
| iss_tag | output | 3*TAGW | Destination tag of each grant |
| wb_div | output | 1 | Divider owns the shared writeback port |
| wb_pipe | output | 1 | Unit 1 owns the shared writeback port |

## Verification
The assertions rely on the divider model around the block. It raises `div_claim` only while a divide is in flight and at most once per divide. It does so at least one cycle after the grant and never while an earlier claim is still pending. The bench's divider model keeps to this rule: it counts down a random delay from each divide grant it predicts and issues exactly one claim pulse. Every other input is random, except for periodic all-ones broadcasts that drain stuck entries, and a reference model predicts every output on every cycle.

// File: rtl/sched_pkg.sv
// Shared constants for the issue scheduler.
// Assumes: exactly two pipelined unit classes plus one divider class.
package sched_pkg;
    localparam int UNIT_W   = 2;
    localparam int NUNIT    = 3;
    localparam int UNIT_P0  = 0;
    localparam int UNIT_P1  = 1;
    localparam int UNIT_DIV = 2;
    localparam int NPIPE    = 2;
endpackage

// File: rtl/sched_window.sv
// Entry array: valid bits, decoded pending-source masks, class and destination.
// Wakeup clears pending bits by AND with the inverted wakeup bus; no encoder.
// Assumes: clr_mask only names valid entries; wr_en only when has_free.
module sched_window
    import sched_pkg::*;
#(
    parameter int N    = 16,
    parameter int TAGW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [TAGW-1:0]               wr_src0,
    input  logic [TAGW-1:0]               wr_src1,
    input  logic [TAGW-1:0]               wr_dst,
    input  logic [UNIT_W-1:0]             wr_unit,
    input  logic [TAGW-1:0]               wake,
    input  logic [N-1:0]                  clr_mask,
    output logic [N-1:0]                  rdy,
    output logic [N-1:0][UNIT_W-1:0]      unit_o,
    output logic [N-1:0][TAGW-1:0]        dst_o,
    output logic                          has_free,
    output logic [$clog2(N)-1:0]          free_idx
);
    localparam int IDXW = $clog2(N);

    logic [N-1:0]             vld_q;
    logic [N-1:0][TAGW-1:0]   pend_q;
    logic [N-1:0][UNIT_W-1:0] unit_q;
    logic [N-1:0][TAGW-1:0]   dst_q;

    // Find the lowest invalid slot for dispatch.
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                has_free = 1'b1;
                free_idx = IDXW'(i);
            end
        end
    end

    // Entry state: allocate, wake pending sources, free on grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (clr_mask[i]) vld_q[i] <= 1'b0;
                pend_q[i] <= pend_q[i] & ~wake;
                if (wr_en && free_idx == IDXW'(i)) begin
                    vld_q[i]  <= 1'b1;
                    pend_q[i] <= (wr_src0 | wr_src1) & ~wake;
                    unit_q[i] <= wr_unit;
                    dst_q[i]  <= wr_dst;
                end
            end
        end
    end

    // Ready when valid with no pending source.
    always_comb begin
        for (int i = 0; i < N; i++) rdy[i] = vld_q[i] && (pend_q[i] == '0);
    end

    assign unit_o = unit_q;
    assign dst_o  = dst_q;

    AST_DISPATCH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld_q[$past(free_idx)]); // R9
endmodule

// File: rtl/sched_pick.sv
// Find-first picker: grants the lowest-index requester.
// Assumes: requests are already qualified by class and unit availability.
module sched_pick #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic                 gnt_vld,
    output logic [N-1:0]         gnt_oh,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IDXW = $clog2(N);

    // Isolate the lowest set request bit.
    assign gnt_oh  = req & (~req + {{(N-1){1'b0}}, 1'b1});
    assign gnt_vld = |req;

    // Encode the one-hot grant into a slot index.
    always_comb begin
        gnt_idx = '0;
        for (int i = 0; i < N; i++) if (gnt_oh[i]) gnt_idx = gnt_idx | IDXW'(i);
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh) && ((gnt_oh & ~req) == '0)); // R3
endmodule

// File: rtl/sched_wb_resv.sv
// Divider busy tracking and writeback-slot reservation for the shared port.
// A claim shifts through LEAD stages; the last stage is divider ownership and
// the stage before it blocks a unit-1 issue (unit-1 latency is one cycle).
// Assumes: claim comes once per divide, while busy, with no claim pending.
module sched_wb_resv #(
    parameter int LEAD = 3,
    parameter int TAGW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            claim,
    input  logic            div_iss,
    input  logic [TAGW-1:0] div_tag,
    input  logic            pipe_iss,
    output logic            wb_div,
    output logic            wb_pipe,
    output logic            blk_pipe,
    output logic            busy,
    output logic [TAGW-1:0] div_bcast
);
    logic [LEAD-1:0] res_q;
    logic            busy_q;
    logic            pipe_q;
    logic [TAGW-1:0] tag_q;

    // Shift the reservation and record unit-1 writeback ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            pipe_q <= 1'b0;
        end else begin
            res_q  <= {res_q[LEAD-2:0], claim};
            pipe_q <= pipe_iss;
        end
    end

    // Divider occupancy from grant until its writeback cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (div_iss) begin
            busy_q <= 1'b1;
            tag_q  <= div_tag;
        end else if (wb_div) begin
            busy_q <= 1'b0;
        end
    end

    assign wb_div    = res_q[LEAD-1];
    assign blk_pipe  = res_q[LEAD-2];
    assign wb_pipe   = pipe_q;
    assign busy      = busy_q;
    assign div_bcast = wb_div ? tag_q : '0;

    AST_WB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_div && wb_pipe)); // R8
    AST_DIV_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        div_iss |=> busy_q); // R6
    AST_WB_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_div |-> $past(claim, 3)); // R7
endmodule

// File: rtl/issue_sched.sv
// Top of the wakeup/select issue scheduler. One picker per unit class is
// generated; pipelined grant tags feed the wakeup bus in the same cycle.
// Assumes: one-hot tags; divider claim protocol as in sched_wb_resv.
module issue_sched
    import sched_pkg::*;
#(
    parameter int N       = 16,
    parameter int TAGW    = 16,
    parameter int WB_LEAD = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          disp_valid,
    output logic                          disp_ready,
    input  logic [TAGW-1:0]               disp_src0,
    input  logic [TAGW-1:0]               disp_src1,
    input  logic [TAGW-1:0]               disp_dst,
    input  logic [UNIT_W-1:0]             disp_unit,
    input  logic [TAGW-1:0]               ext_bcast,
    input  logic                          div_claim,
    output logic [NUNIT-1:0]              iss_vld,
    output logic [NUNIT*$clog2(N)-1:0]    iss_slot,
    output logic [NUNIT*TAGW-1:0]         iss_tag,
    output logic                          wb_div,
    output logic                          wb_pipe
);
    localparam int IDXW = $clog2(N);

    logic [N-1:0]             rdy;
    logic [N-1:0][UNIT_W-1:0] unit_q;
    logic [N-1:0][TAGW-1:0]   dst_q;
    logic                     has_free;
    logic [IDXW-1:0]          free_idx;
    logic [TAGW-1:0]          wake;
    logic [TAGW-1:0]          div_bcast;
    logic [N-1:0]             clr_mask;
    logic                     blk_pipe;
    logic                     div_busy;
    logic [NUNIT-1:0][N-1:0]  gnt_oh;
    logic [NUNIT-1:0][IDXW-1:0] gnt_idx;

    assign disp_ready = has_free;

    sched_window #(.N(N), .TAGW(TAGW)) u_win (
        .clk(clk), .rst_n(rst_n),
        .wr_en(disp_valid && has_free),
        .wr_src0(disp_src0), .wr_src1(disp_src1),
        .wr_dst(disp_dst), .wr_unit(disp_unit),
        .wake(wake), .clr_mask(clr_mask),
        .rdy(rdy), .unit_o(unit_q), .dst_o(dst_q),
        .has_free(has_free), .free_idx(free_idx)
    );

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic [N-1:0] req;
        logic         open;
        // Availability gate: unit 1 yields to reserved slot, divider to busy.
        assign open = (u == UNIT_P1)  ? !blk_pipe :
                      (u == UNIT_DIV) ? !div_busy : 1'b1;
        // Qualify ready entries by class.
        always_comb begin
            for (int i = 0; i < N; i++)
                req[i] = rdy[i] && (unit_q[i] == UNIT_W'(u)) && open;
        end
        sched_pick #(.N(N)) u_pick (
            .clk(clk), .rst_n(rst_n), .req(req),
            .gnt_vld(iss_vld[u]), .gnt_oh(gnt_oh[u]), .gnt_idx(gnt_idx[u])
        );
        assign iss_slot[u*IDXW +: IDXW] = gnt_idx[u];
        assign iss_tag[u*TAGW +: TAGW]  = dst_q[gnt_idx[u]];
    end

    // Wakeup bus and deallocation mask from this cycle's grants.
    always_comb begin
        wake     = ext_bcast | div_bcast;
        clr_mask = '0;
        for (int u = 0; u < NUNIT; u++) begin
            clr_mask = clr_mask | gnt_oh[u];
            if (u < NPIPE && iss_vld[u]) wake = wake | iss_tag[u*TAGW +: TAGW];
        end
    end

    sched_wb_resv #(.LEAD(WB_LEAD), .TAGW(TAGW)) u_wb (
        .clk(clk), .rst_n(rst_n), .claim(div_claim),
        .div_iss(iss_vld[UNIT_DIV]),
        .div_tag(iss_tag[UNIT_DIV*TAGW +: TAGW]),
        .pipe_iss(iss_vld[UNIT_P1]),
        .wb_div(wb_div), .wb_pipe(wb_pipe), .blk_pipe(blk_pipe),
        .busy(div_busy), .div_bcast(div_bcast)
    );

    AST_NO_DOUBLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt_oh[0] & gnt_oh[1], gnt_oh[1] & gnt_oh[2]}) &&
        ((gnt_oh[0] & gnt_oh[1]) == '0) && ((gnt_oh[0] & gnt_oh[2]) == '0)
        && ((gnt_oh[1] & gnt_oh[2]) == '0)); // R3
endmodule

// File: tb/tb_issue_sched.sv
module tb_issue_sched;
    localparam int N = 16;
    localparam int TW = 16;
    localparam int IW = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic disp_valid = 0;
    logic disp_ready;
    logic [TW-1:0] disp_src0 = 0, disp_src1 = 0, disp_dst = 0, ext_bcast = 0;
    logic [1:0] disp_unit = 0;
    logic div_claim = 0;
    logic [2:0] iss_vld;
    logic [3*IW-1:0] iss_slot;
    logic [3*TW-1:0] iss_tag;
    logic wb_div, wb_pipe;

    always #4 clk = ~clk;

    issue_sched dut (.clk(clk), .rst_n(rst_n), .disp_valid(disp_valid),
        .disp_ready(disp_ready), .disp_src0(disp_src0), .disp_src1(disp_src1),
        .disp_dst(disp_dst), .disp_unit(disp_unit), .ext_bcast(ext_bcast),
        .div_claim(div_claim), .iss_vld(iss_vld), .iss_slot(iss_slot),
        .iss_tag(iss_tag), .wb_div(wb_div), .wb_pipe(wb_pipe));

    int checks = 0, errors = 0, cyc = 0;
    // reference model
    bit m_v[N];
    logic [TW-1:0] m_p[N], m_d[N];
    int m_u[N];
    bit m_busy = 0, m_p1 = 0;
    logic [TW-1:0] m_dtag = 0;
    int wb_at = -100, dcd = 0;
    int g[3];

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", r, what, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) m_v[i] = 0;
        m_busy = 0; m_p1 = 0; wb_at = -100; dcd = 0;
    endtask

    // Compare this cycle's outputs with the model, then advance the model.
    task automatic cyc_go();
        int fr;
        bit ewd;
        logic [TW-1:0] wk;
        div_claim = (dcd == 1);
        #1;
        fr = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_v[i]) fr = i;
        for (int u = 0; u < 3; u++) begin
            g[u] = -1;
            for (int i = N - 1; i >= 0; i--)
                if (m_v[i] && m_p[i] == 0 && m_u[i] == u &&
                    !(u == 1 && wb_at == cyc + 1) && !(u == 2 && m_busy)) g[u] = i;
        end
        ewd = (wb_at == cyc);
        chk("R9", "disp_ready", disp_ready, fr >= 0);
        for (int u = 0; u < 3; u++) begin
            string r;
            r = (u == 2) ? "R6" : (u == 1) ? "R8" : "R3";
            chk(r, $sformatf("iss_vld[%0d]", u), iss_vld[u], g[u] >= 0);
            if (g[u] >= 0) begin
                chk("R3", $sformatf("iss_slot[%0d]", u), iss_slot[u*IW +: IW], g[u]);
                chk("R3", $sformatf("iss_tag[%0d]", u), iss_tag[u*TW +: TW], m_d[g[u]]);
            end
        end
        chk("R7", "wb_div", wb_div, ewd);
        chk("R8", "wb_pipe", wb_pipe, m_p1);
        // next state
        wk = ext_bcast | (ewd ? m_dtag : '0);
        for (int u = 0; u < 2; u++) if (g[u] >= 0) wk |= m_d[g[u]];
        for (int u = 0; u < 3; u++) if (g[u] >= 0) m_v[g[u]] = 0;
        for (int i = 0; i < N; i++) m_p[i] &= ~wk;
        if (disp_valid && fr >= 0) begin
            m_v[fr] = 1; m_p[fr] = (disp_src0 | disp_src1) & ~wk;
            m_u[fr] = disp_unit; m_d[fr] = disp_dst;
        end
        if (div_claim) wb_at = cyc + 3;
        if (dcd > 0) dcd--;
        if (g[2] >= 0) begin
            m_busy = 1; m_dtag = m_d[g[2]]; dcd = 1 + ($urandom % 5);
        end else if (ewd) m_busy = 0;
        m_p1 = (g[1] >= 0);
    endtask

    task automatic adv();
        @(posedge clk); cyc++; @(negedge clk);
    endtask

    task automatic disp(int u, logic [TW-1:0] s0, logic [TW-1:0] s1, logic [TW-1:0] d);
        disp_valid = 1; disp_unit = 2'(u); disp_src0 = s0; disp_src1 = s1; disp_dst = d;
    endtask

    task automatic idle();
        disp_valid = 0; ext_bcast = 0;
    endtask

    function automatic logic [TW-1:0] oh(int k);
        return TW'(1) << k;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int c0;
        @(negedge clk);
        rst_n = 0;
        repeat (3) adv();
        rst_n = 1;
        model_reset();
        #1;
        chk("R1", "disp_ready after reset", disp_ready, 1);
        chk("R1", "iss_vld after reset", iss_vld, 0);
        chk("R1", "wb after reset", {wb_div, wb_pipe}, 0);
        #1;
        // R4: back-to-back producer/consumer on unit 0
        disp(0, 0, 0, oh(3)); cyc_go(); adv();
        disp(0, oh(3), 0, oh(4)); cyc_go();
        chk("R4", "producer granted", iss_vld[0], 1);
        adv(); idle(); cyc_go();
        chk("R4", "dependent next cycle", iss_vld[0], 1);
        chk("R4", "dependent slot", iss_slot[IW-1:0], 1);
        adv();
        // R2: pending source holds the entry until broadcast
        disp(1, oh(7), 0, oh(8)); cyc_go(); adv(); idle();
        repeat (3) begin cyc_go(); chk("R2", "held on tag 7", iss_vld[1], 0); adv(); end
        ext_bcast = oh(7); cyc_go(); adv(); ext_bcast = 0; cyc_go();
        chk("R2", "issues after tag 7", iss_vld[1], 1);
        adv();
        // R5: broadcast in dispatch cycle
        disp(0, oh(9), oh(9), oh(10)); ext_bcast = oh(9); cyc_go(); adv(); idle(); cyc_go();
        chk("R5", "same-cycle wake", iss_vld[0], 1);
        adv();
        // R6/R7/R8: divide, reservation, unit-1 hold and divide tag wakeup
        disp(2, 0, 0, oh(12)); cyc_go(); adv();
        disp(2, 0, 0, oh(13)); cyc_go(); chk("R6", "first divide", iss_vld[2], 1); adv();
        disp(0, oh(12), 0, oh(14)); c0 = -1;
        for (int k = 0; k < 20; k++) begin
            cyc_go();
            if (div_claim) c0 = cyc;
            if (c0 >= 0 && cyc == c0 + 2) chk("R8", "unit1 held", iss_vld[1], 0);
            if (c0 >= 0 && cyc == c0 + 3) chk("R7", "wb_div at claim+3", wb_div, 1);
            if (c0 < 0) chk("R6", "second divide waits", iss_vld[2], 0);
            adv();
            if (k == 0) idle();
            disp(1, 0, 0, oh(15));
        end
        idle();
        // R9: fill the window with blocked entries
        for (int k = 0; k < N + 2; k++) begin disp(0, oh(0), 0, oh(1)); cyc_go(); adv(); end
        idle(); cyc_go(); chk("R9", "full window", disp_ready, 0); adv();
        ext_bcast = '1; cyc_go(); adv(); idle();
        // random run
        for (int k = 0; k < 4000; k++) begin
            disp_valid = ($urandom % 10) < 6;
            disp_unit = 2'($urandom % 3);
            disp_src0 = ($urandom % 2) ? oh($urandom % TW) : '0;
            disp_src1 = ($urandom % 2) ? oh($urandom % TW) : '0;
            disp_dst = oh($urandom % TW);
            ext_bcast = ($urandom % 10 < 4) ? oh($urandom % TW) : '0;
            if (k % 50 == 49) ext_bcast = '1;
            cyc_go(); adv();
        end
        idle();
        repeat (20) begin ext_bcast = '1; cyc_go(); adv(); end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule